// File: doc/BRIEF.md
# Scalar Lane Move-Merge Unit

This datapath stage builds the result of a scalar 32-bit floating-point move for a 512-bit vector register file. Each cycle with `in_valid` high, it takes the old destination register value, two source register values, a 32-bit memory word, a one-bit mask predicate and three control fields. From these it forms the new destination value, a register write enable, a store word with its enable, and an undefined-opcode fault flag. The control fields are the encoding class (legacy, VEX, EVEX), the operand form (register-register, load, store) and the masking mode (off, merge, zero).

The result depends on how the encoding class and operand form combine. The legacy class keeps the old upper bits in places where the newer classes copy from the first source or clear the bits. The EVEX class adds write-masking, which affects the low 32-bit element only.

The block does no decode, address generation or memory access. Results appear one clock after the request, together with `out_valid`.

Top module: `scalar_lane_merge`

## Requirements
- R1: Legacy class (`enc_class`=0), register form (`op_form`=0): `dst_new[31:0]` = `src2[31:0]`, and `dst_new[511:32]` = `dst_old[511:32]`; `reg_we`=1.
- R2: Legacy class, load form (`op_form`=1): `dst_new[31:0]` = `mem_word`, `dst_new[127:32]` = 0, and `dst_new[511:128]` = `dst_old[511:128]`; `reg_we`=1.
- R3: VEX (`enc_class`=1) or EVEX (`enc_class`=2) register form with the low element written: `dst_new[31:0]` = `src2[31:0]`, `dst_new[127:32]` = `src1[127:32]`, and `dst_new[511:128]` = 0.
- R4: VEX or EVEX load form with the low element written: `dst_new[31:0]` = `mem_word`, and `dst_new[511:32]` = 0.
- R5: With EVEX, a masking mode of merge (`mask_mode`=1) or zero (`mask_mode`=2), and `pred_bit`=0, the low element is not written. Merge keeps `dst_old[31:0]` and zero gives 0. Bits 511:32 still follow R3 or R4, and `reg_we`=1. With `mask_mode`=0, or with `pred_bit`=1, the element is written normally.
- R6: Store form (`op_form`=2): `reg_we`=0, `st_data` = `src2[31:0]`, and `st_we`=1, except that EVEX merge-masking with `pred_bit`=0 gives `st_we`=0 and no fault.
- R7: A VEX or EVEX store with `vvvv` other than 4'b1111 raises `ud_fault` and clears both `reg_we` and `st_we`. A legacy store ignores `vvvv`.
- R8: Each of the following raises `ud_fault` with both write enables low: `op_form`=3 (memory to memory), `enc_class`=3, `mask_mode`=3, a `mask_mode` other than 0 on a non-EVEX class, or zero-masking on a store.
- R9: Outputs are registered with one cycle of latency, and `out_valid` equals the `in_valid` of the previous cycle. When `in_valid` was low, `reg_we`, `st_we` and `ud_fault` are low.
- R10: While `rst_n` is low, `out_valid`, `reg_we`, `st_we` and `ud_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| enc_class | input | 2 | 0 legacy, 1 VEX, 2 EVEX, 3 reserved |
| op_form | input | 2 | 0 reg-reg, 1 load, 2 store, 3 memory-memory (illegal) |
| mask_mode | input | 2 | 0 none, 1 merge, 2 zero, 3 reserved |
| pred_bit | input | 1 | Bit 0 of the selected mask register |
| vvvv | input | 4 | Extra register specifier field |
| dst_old | input | 512 | Present destination register value |
| src1 | input | 512 | First source register value |
| src2 | input | 512 | Second source (store source) register value |
| mem_word | input | 32 | Memory operand for loads |
| out_valid | output | 1 | Result valid |
| dst_new | output | 512 | New destination register value |
| reg_we | output | 1 | Register write enable |
| st_data | output | 32 | Store data word |
| st_we | output | 1 | Store enable |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The bench sweeps every value of the encoding class, operand form, masking mode, predicate and a legal or illegal `vvvv` (256 control patterns) over two data sets. In each data set, every 32-bit word of `dst_old`, `src1`, `src2` and `mem_word` holds a distinct value. Because of this, any wrong source, or any wrong boundary at bit 32 or bit 128, shows up as a wrong word. Zero values in the result tell a clear apart from a copy. Comparing the merge and zero masked cases against the predicate-set cases separates the masking from the upper-bit rules. Idle cycles and a reset in the middle of the run check the valid and enable behaviour.

// File: rtl/slm_pkg.sv
package slm_pkg;
  typedef enum logic [1:0] {
    ENC_LEGACY = 2'd0,
    ENC_VEX    = 2'd1,
    ENC_EVEX   = 2'd2,
    ENC_RSVD   = 2'd3
  } enc_e;

  typedef enum logic [1:0] {
    FORM_REG   = 2'd0,
    FORM_LOAD  = 2'd1,
    FORM_STORE = 2'd2,
    FORM_M2M   = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    MASK_OFF   = 2'd0,
    MASK_MERGE = 2'd1,
    MASK_ZERO  = 2'd2,
    MASK_RSVD  = 2'd3
  } mask_e;

  typedef enum logic [1:0] {
    LOW_SRC2 = 2'd0,
    LOW_MEM  = 2'd1,
    LOW_OLD  = 2'd2,
    LOW_ZERO = 2'd3
  } low_sel_e;

  typedef enum logic [1:0] {
    MID_OLD  = 2'd0,
    MID_SRC1 = 2'd1,
    MID_ZERO = 2'd2
  } mid_sel_e;

  typedef enum logic {
    HI_OLD  = 1'b0,
    HI_ZERO = 1'b1
  } hi_sel_e;
endpackage

// File: rtl/slm_classify.sv
module slm_classify
  import slm_pkg::*;
#(
  parameter int VV_W = 4
) (
  input  enc_e            enc,
  input  form_e           form,
  input  mask_e           mmode,
  input  logic            pred,
  input  logic [VV_W-1:0] vv,
  output logic            fault,
  output logic            do_reg,
  output logic            do_st,
  output low_sel_e        low_sel,
  output mid_sel_e        mid_sel,
  output hi_sel_e         hi_sel
);
  logic masked_off;

  always_comb begin
    masked_off = (mmode != MASK_OFF) && !pred;
    fault      = 1'b0;
    do_reg     = 1'b0;
    do_st      = 1'b0;
    low_sel    = LOW_OLD;
    mid_sel    = MID_OLD;
    hi_sel     = HI_OLD;
    if (enc == ENC_RSVD || form == FORM_M2M || mmode == MASK_RSVD) begin
      fault = 1'b1;
    end else if (enc != ENC_EVEX && mmode != MASK_OFF) begin
      fault = 1'b1;
    end else if (form == FORM_STORE && mmode == MASK_ZERO) begin
      fault = 1'b1;
    end else if (form == FORM_STORE && enc != ENC_LEGACY && vv != {VV_W{1'b1}}) begin
      fault = 1'b1;
    end else begin
      unique case (form)
        FORM_REG: begin
          do_reg  = 1'b1;
          low_sel = LOW_SRC2;
          mid_sel = (enc == ENC_LEGACY) ? MID_OLD : MID_SRC1;
          hi_sel  = (enc == ENC_LEGACY) ? HI_OLD : HI_ZERO;
        end
        FORM_LOAD: begin
          do_reg  = 1'b1;
          low_sel = LOW_MEM;
          mid_sel = MID_ZERO;
          hi_sel  = (enc == ENC_LEGACY) ? HI_OLD : HI_ZERO;
        end
        default: begin
          do_st = !masked_off;
        end
      endcase
      if (masked_off && form != FORM_STORE) begin
        low_sel = (mmode == MASK_MERGE) ? LOW_OLD : LOW_ZERO;
      end
    end
  end

  // R8
  always_comb begin
    fault_excl_chk: assert (!(fault && (do_reg || do_st)));
  end
endmodule

// File: rtl/slm_compose.sv
module slm_compose
  import slm_pkg::*;
#(
  parameter int VLEN = 512,
  parameter int ELEM = 32,
  parameter int LANE = 128
) (
  input  logic [VLEN-1:0] old_v,
  input  logic [VLEN-1:0] s1_v,
  input  logic [VLEN-1:0] s2_v,
  input  logic [ELEM-1:0] mem_v,
  input  low_sel_e        low_sel,
  input  mid_sel_e        mid_sel,
  input  hi_sel_e         hi_sel,
  output logic [VLEN-1:0] res_v
);
  localparam int NWORD = VLEN / ELEM;
  localparam int LWORD = LANE / ELEM;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    if (w == 0) begin : g_low
      always_comb begin
        unique case (low_sel)
          LOW_SRC2: res_v[ELEM-1:0] = s2_v[ELEM-1:0];
          LOW_MEM:  res_v[ELEM-1:0] = mem_v;
          LOW_OLD:  res_v[ELEM-1:0] = old_v[ELEM-1:0];
          default:  res_v[ELEM-1:0] = '0;
        endcase
      end
    end else if (w < LWORD) begin : g_mid
      always_comb begin
        unique case (mid_sel)
          MID_OLD:  res_v[w*ELEM +: ELEM] = old_v[w*ELEM +: ELEM];
          MID_SRC1: res_v[w*ELEM +: ELEM] = s1_v[w*ELEM +: ELEM];
          default:  res_v[w*ELEM +: ELEM] = '0;
        endcase
      end
    end else begin : g_hi
      always_comb begin
        res_v[w*ELEM +: ELEM] = (hi_sel == HI_OLD) ? old_v[w*ELEM +: ELEM] : '0;
      end
    end
  end
endmodule

// File: rtl/scalar_lane_merge.sv
module scalar_lane_merge
  import slm_pkg::*;
#(
  parameter int VLEN = 512,
  parameter int ELEM = 32,
  parameter int LANE = 128,
  parameter int VV_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      enc_class,
  input  logic [1:0]      op_form,
  input  logic [1:0]      mask_mode,
  input  logic            pred_bit,
  input  logic [VV_W-1:0] vvvv,
  input  logic [VLEN-1:0] dst_old,
  input  logic [VLEN-1:0] src1,
  input  logic [VLEN-1:0] src2,
  input  logic [ELEM-1:0] mem_word,
  output logic            out_valid,
  output logic [VLEN-1:0] dst_new,
  output logic            reg_we,
  output logic [ELEM-1:0] st_data,
  output logic            st_we,
  output logic            ud_fault
);
  logic     c_fault, c_reg, c_st;
  low_sel_e c_low;
  mid_sel_e c_mid;
  hi_sel_e  c_hi;
  logic [VLEN-1:0] c_res;

  logic            valid_d, reg_we_d, st_we_d, fault_d;
  logic [VLEN-1:0] dst_d;
  logic [ELEM-1:0] st_data_d;

  slm_classify #(.VV_W(VV_W)) u_class (
    .enc     (enc_e'(enc_class)),
    .form    (form_e'(op_form)),
    .mmode   (mask_e'(mask_mode)),
    .pred    (pred_bit),
    .vv      (vvvv),
    .fault   (c_fault),
    .do_reg  (c_reg),
    .do_st   (c_st),
    .low_sel (c_low),
    .mid_sel (c_mid),
    .hi_sel  (c_hi)
  );

  slm_compose #(.VLEN(VLEN), .ELEM(ELEM), .LANE(LANE)) u_comp (
    .old_v   (dst_old),
    .s1_v    (src1),
    .s2_v    (src2),
    .mem_v   (mem_word),
    .low_sel (c_low),
    .mid_sel (c_mid),
    .hi_sel  (c_hi),
    .res_v   (c_res)
  );

  always_comb begin
    valid_d   = in_valid;
    reg_we_d  = in_valid && c_reg;
    st_we_d   = in_valid && c_st;
    fault_d   = in_valid && c_fault;
    dst_d     = c_res;
    st_data_d = src2[ELEM-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      reg_we    <= 1'b0;
      st_we     <= 1'b0;
      ud_fault  <= 1'b0;
    end else begin
      out_valid <= valid_d;
      reg_we    <= reg_we_d;
      st_we     <= st_we_d;
      ud_fault  <= fault_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      dst_new <= dst_d;
      st_data <= st_data_d;
    end
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !reg_we && !st_we && !ud_fault));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R6
  we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && st_we));

  // R8
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> (!reg_we && !st_we));

  // R1
  legacy_upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_class == 2'd0 && op_form == 2'd0 && mask_mode == 2'd0)
    |=> (dst_new[VLEN-1:ELEM] == $past(dst_old[VLEN-1:ELEM])));

  // R4
  vex_load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enc_class == 2'd1 && op_form == 2'd1 && mask_mode == 2'd0)
    |=> (dst_new[VLEN-1:ELEM] == '0 && dst_new[ELEM-1:0] == $past(mem_word)));
endmodule

// File: tb/tb_scalar_lane_merge.sv
module tb_scalar_lane_merge;
  localparam int VLEN = 512;
  localparam int ELEM = 32;
  localparam int NW   = VLEN / ELEM;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [1:0]      enc_class, op_form, mask_mode;
  logic            pred_bit;
  logic [3:0]      vvvv;
  logic [VLEN-1:0] dst_old, src1, src2;
  logic [ELEM-1:0] mem_word;
  logic            out_valid, reg_we, st_we, ud_fault;
  logic [VLEN-1:0] dst_new;
  logic [ELEM-1:0] st_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  scalar_lane_merge dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enc_class(enc_class),
    .op_form(op_form), .mask_mode(mask_mode), .pred_bit(pred_bit), .vvvv(vvvv),
    .dst_old(dst_old), .src1(src1), .src2(src2), .mem_word(mem_word),
    .out_valid(out_valid), .dst_new(dst_new), .reg_we(reg_we),
    .st_data(st_data), .st_we(st_we), .ud_fault(ud_fault)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill(input int set);
    for (int w = 0; w < NW; w++) begin
      dst_old[w*ELEM +: ELEM] = 32'hD000_0000 | (set << 12) | w;
      src1[w*ELEM +: ELEM]    = 32'hA100_0000 | (set << 12) | w;
      src2[w*ELEM +: ELEM]    = 32'hB200_0000 | (set << 12) | w;
    end
    mem_word = 32'hC3DE_0000 | set;
  endtask

  task automatic run_case(input int e, input int f, input int m, input int p, input int vbad);
    bit              flt;
    bit              e_reg, e_st, moff;
    string           tag;
    logic [VLEN-1:0] exp;
    flt  = 0;
    tag  = "R8";
    moff = (m != 0) && (p == 0);
    if (e == 3 || f == 3 || m == 3) flt = 1;
    else if (e != 2 && m != 0) flt = 1;
    else if (f == 2 && m == 2) flt = 1;
    else if (f == 2 && e != 0 && vbad != 0) begin flt = 1; tag = "R7"; end
    e_reg = !flt && (f == 0 || f == 1);
    e_st  = !flt && f == 2 && !moff;
    exp   = dst_old;
    if (!flt && f == 0) begin
      if (e == 0) begin tag = "R1"; end
      else begin tag = "R3"; exp = '0; exp[127:32] = src1[127:32]; end
      exp[31:0] = src2[31:0];
    end else if (!flt && f == 1) begin
      if (e == 0) begin tag = "R2"; exp[127:32] = '0; end
      else begin tag = "R4"; exp = '0; end
      exp[31:0] = mem_word;
    end else if (!flt && f == 2) begin
      tag = (e == 0 && vbad != 0) ? "R7" : "R6";
    end
    if (!flt && f != 2 && moff) begin
      tag = "R5";
      exp[31:0] = (m == 1) ? dst_old[31:0] : 32'h0;
    end
    if (!flt && f == 2 && moff) tag = "R6";
    @(negedge clk);
    in_valid  = 1'b1;
    enc_class = e[1:0];
    op_form   = f[1:0];
    mask_mode = m[1:0];
    pred_bit  = p[0];
    vvvv      = vbad != 0 ? 4'b0110 : 4'b1111;
    @(negedge clk);
    chk(out_valid == 1'b1, "R9", "out_valid", VLEN'(out_valid), VLEN'(1));
    chk(ud_fault == flt, tag, "ud_fault", VLEN'(ud_fault), VLEN'(flt));
    chk(reg_we == e_reg, tag, "reg_we", VLEN'(reg_we), VLEN'(e_reg));
    chk(st_we == e_st, tag, "st_we", VLEN'(st_we), VLEN'(e_st));
    if (e_reg) chk(dst_new == exp, tag, "dst_new", dst_new, exp);
    if (e_st) chk(st_data == src2[31:0], "R6", "st_data", VLEN'(st_data), VLEN'(src2[31:0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; enc_class = 2'd0; op_form = 2'd0;
    mask_mode = 2'd0; pred_bit = 1'b1; vvvv = 4'hF;
    fill(0);
    repeat (3) @(negedge clk);
    // R10: reset state while requests are presented
    chk({out_valid, reg_we, st_we, ud_fault} == 4'b0, "R10", "flags in reset",
        VLEN'({out_valid, reg_we, st_we, ud_fault}), '0);
    rst_n = 1'b1;
    for (int set = 1; set <= 2; set++) begin
      fill(set);
      for (int e = 0; e < 4; e++)
        for (int f = 0; f < 4; f++)
          for (int m = 0; m < 4; m++)
            for (int p = 0; p < 2; p++)
              for (int vb = 0; vb < 2; vb++)
                run_case(e, f, m, p, vb);
      // R9: an idle cycle gives no enables and no fault
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk({out_valid, reg_we, st_we, ud_fault} == 4'b0, "R9", "idle flags",
          VLEN'({out_valid, reg_we, st_we, ud_fault}), '0);
    end
    // R10: reset in the middle of the run clears flags
    in_valid = 1'b1; enc_class = 2'd0; op_form = 2'd2; mask_mode = 2'd0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({out_valid, reg_we, st_we, ud_fault} == 4'b0, "R10", "flags after reset",
        VLEN'({out_valid, reg_we, st_we, ud_fault}), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule